// File: doc/BRIEF.md
# Register-Mapped I2C Target

This block is the serial front end of a small configuration peripheral. A fast system clock samples the two bus lines. The block finds START, repeated START and STOP conditions, checks the first byte after every START against a fixed 7-bit device identity, and then runs single-register write and read transfers against an internal bank of byte-wide registers. It never drives the data line high. It only pulls it low through an open-drain output enable, to acknowledge or to send zero bits.

A write transfer has four parts: the device byte with the direction bit low, a register index, one data byte, and then a STOP or a repeated START. After the target has acknowledged the data byte, it pulses a one-clock write strobe toward the host logic, carrying the index and the data. A read transfer first sets the register index with a write-direction header. A repeated START with the direction bit high then follows, and the target shifts the selected register out. The target refuses a register index outside the implemented bank by leaving the acknowledge bit released. It then stays silent until the bus is re-armed by a STOP or a START.

Both lines pass through a synchronizer and a run-length glitch filter. The system clock must therefore run at least sixteen times faster than the fastest serial clock (400 kHz).

Top module: `i2c_reg_target`

## Requirements
- R1: The target acknowledges (pulls SDA low during the ninth clock) only an address byte whose upper seven bits equal DEV_ADDR (0x2A, so 0x54 for write and 0x55 for read; bit 0 set means read). Any other address byte is left unacknowledged, and every later byte is left unacknowledged until the next START.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START that arrives in the middle of a transfer, including right after a completed write, restarts address matching.
- R3: The register-index byte is acknowledged only when it is below NUM_REGS (8). Otherwise it is refused, the following data byte is refused too, and no write takes place.
- R4: The data byte of a write is acknowledged. wr_stb then pulses high for exactly one system clock, after the acknowledge clock, with wr_addr holding the index and wr_data holding the byte. A later read of that index returns the byte.
- R5: A read returns the register selected by the last accepted index, most significant bit first. The target changes its SDA drive only while SCL is low.
- R6: When the controller acknowledges a read byte, the same register is sent again. When the controller does not acknowledge, the target releases SDA, and any further bits read as 1 until the next START or STOP.
- R7: After reset, register i holds 0xA0 + i, SDA is released and wr_stb is low.
- R8: A pulse on SCL or SDA that lasts fewer than FILT_LEN (3) system clocks is ignored. It creates no bit, START or STOP.
- R9: After the data byte of a write, a further byte in the same transfer is refused and does not produce a second strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_stb | output | 1 | One-clock register write strobe |
| wr_addr | output | 8 | Register index of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
A wrong transfer state shows up within one bit time. The target then acknowledges a byte it should refuse, or the reverse, and the controller sees that at the next ninth-clock sample. A corrupted shift or bit count surfaces as a wrong read byte, or as a strobe with the wrong index or data at the end of the same transfer. A drive change during SCL high is caught at the system clock where it happens. A filter fault appears as a stray strobe, a wrong acknowledge, or corrupted data in the transfer that carries the glitch.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_IGNORE
  } tgt_state_e;

  // Power-up contents of register idx.
  function automatic logic [7:0] reg_reset_value(input int unsigned idx);
    return 8'(8'hA0 + idx);
  endfunction

  // Upper seven bits of the first byte after START name the device.
  function automatic logic addr_byte_match(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // A register index is implemented when it lies below the bank size.
  function automatic logic reg_addr_valid(input logic [7:0] a, input int unsigned n);
    return {24'd0, a} < n;
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      filt_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_o) begin
        run_q <= '0;
      end else if (run_q == CNT_W'(FILT_LEN - 1)) begin
        filt_o <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // The filtered line moves only after the synchronized line held its new level.
  AST_FILT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_o) |-> ($past(sync_q[1]) == filt_o) && ($past(sync_q[1], 2) == filt_o)); // R8

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_ev = scl_q & scl_f & sda_q & ~sda_f;
  assign stop_ev  = scl_q & scl_f & ~sda_q & sda_f;
  assign scl_rise = ~scl_q & scl_f;
  assign scl_fall = scl_q & ~scl_f;

endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  import i2c_tgt_pkg::*;

  logic [NUM_REGS-1:0][DW-1:0] regs_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= DW'(reg_reset_value(g));
      else if (we && waddr == AW'(g)) regs_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (raddr == AW'(i)) rdata = regs_q[i];
    end
  end

  AST_WR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ({{(32 - AW){1'b0}}, waddr} < NUM_REGS)); // R3

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0]  DEV_ADDR = 7'h2A,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  import i2c_tgt_pkg::*;

  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  // Line conditioning: index 1 is SCL, index 0 is SDA.
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {scl_i, sda_i};

  for (genvar l = 0; l < 2; l++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_lines[l]),
      .filt_o(filt_lines[l])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  logic start_ev, stop_ev, scl_rise, scl_fall;

  i2c_bus_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  tgt_state_e        state_q;
  logic              phase_q;
  logic [BIT_W-1:0]  bitcnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              rw_q;
  logic              rd_more_q;
  logic [7:0]        ptr_q;
  logic [7:0]        wdata_q;
  logic [7:0]        rd_data;

  logic [BYTE_W-1:0] rx_byte;
  logic              last_bit;
  assign rx_byte  = {shreg_q[BYTE_W-2:0], sda_f};
  assign last_bit = (bitcnt_q == BIT_W'(BYTE_W - 1));

  i2c_regfile #(.NUM_REGS(NUM_REGS), .DW(8), .AW(8)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_stb),
    .waddr(ptr_q),
    .wdata(wdata_q),
    .raddr(ptr_q),
    .rdata(rd_data)
  );

  assign wr_addr = ptr_q;
  assign wr_data = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= 1'b0;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      rw_q      <= 1'b0;
      rd_more_q <= 1'b0;
      ptr_q     <= '0;
      wdata_q   <= '0;
      sda_oe    <= 1'b0;
      wr_stb    <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (stop_ev) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else if (start_ev) begin
        state_q  <= ST_ADDR;
        bitcnt_q <= '0;
        sda_oe   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise) begin
            shreg_q  <= rx_byte;
            bitcnt_q <= bitcnt_q + 1'b1;
            if (last_bit) begin
              if (addr_byte_match(rx_byte, DEV_ADDR)) begin
                rw_q    <= sda_f;
                phase_q <= 1'b0;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (!phase_q) begin
              sda_oe  <= 1'b1;
              phase_q <= 1'b1;
            end else begin
              phase_q  <= 1'b0;
              bitcnt_q <= '0;
              if (rw_q) begin
                state_q <= ST_RDATA;
                shreg_q <= {rd_data[6:0], 1'b0};
                sda_oe  <= ~rd_data[7];
              end else begin
                state_q <= ST_REG;
                sda_oe  <= 1'b0;
              end
            end
          end
          ST_REG: if (scl_rise) begin
            shreg_q  <= rx_byte;
            bitcnt_q <= bitcnt_q + 1'b1;
            if (last_bit) begin
              if (reg_addr_valid(rx_byte, NUM_REGS)) begin
                ptr_q   <= rx_byte;
                phase_q <= 1'b0;
                state_q <= ST_REG_ACK;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          ST_REG_ACK: if (scl_fall) begin
            if (!phase_q) begin
              sda_oe  <= 1'b1;
              phase_q <= 1'b1;
            end else begin
              sda_oe   <= 1'b0;
              phase_q  <= 1'b0;
              bitcnt_q <= '0;
              state_q  <= ST_WDATA;
            end
          end
          ST_WDATA: if (scl_rise) begin
            shreg_q  <= rx_byte;
            bitcnt_q <= bitcnt_q + 1'b1;
            if (last_bit) begin
              wdata_q <= rx_byte;
              phase_q <= 1'b0;
              state_q <= ST_WDATA_ACK;
            end
          end
          ST_WDATA_ACK: if (scl_fall) begin
            if (!phase_q) begin
              sda_oe  <= 1'b1;
              phase_q <= 1'b1;
            end else begin
              sda_oe  <= 1'b0;
              phase_q <= 1'b0;
              wr_stb  <= 1'b1;
              state_q <= ST_IGNORE;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt_q <= bitcnt_q + 1'b1;
              if (last_bit) begin
                phase_q <= 1'b0;
                state_q <= ST_RDATA_ACK;
              end
            end else if (scl_fall) begin
              sda_oe  <= ~shreg_q[BYTE_W-1];
              shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
            end
          end
          ST_RDATA_ACK: begin
            if (scl_fall && !phase_q) begin
              sda_oe  <= 1'b0;
              phase_q <= 1'b1;
            end else if (scl_rise && phase_q) begin
              rd_more_q <= ~sda_f;
            end else if (scl_fall && phase_q) begin
              phase_q <= 1'b0;
              if (rd_more_q) begin
                bitcnt_q <= '0;
                shreg_q  <= {rd_data[6:0], 1'b0};
                sda_oe   <= ~rd_data[7];
                state_q  <= ST_RDATA;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !sda_oe); // R1
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_f)); // R5
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R4
  AST_STB_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(state_q) == ST_WDATA_ACK) && !sda_oe); // R4
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDATA_ACK && phase_q) |-> !sda_oe); // R6

endmodule

// File: tb/test_i2c_reg_target.sv
`timescale 1ns/1ps
module test_i2c_reg_target;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic glitch_sda = 1'b0, glitch_scl = 1'b0;
  logic sda_oe, wr_stb;
  logic [7:0] wr_addr, wr_data;
  logic sda_line, scl_in, sda_in;

  assign sda_line = sda_m & ~sda_oe;
  assign sda_in   = sda_line & ~glitch_sda;
  assign scl_in   = scl_m | glitch_scl;

  always #4 clk = ~clk;

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0, failures = 0;
  int stb_cnt = 0, stb_at_ack = 0, hi_changes = 0;
  logic [7:0] last_a, last_d;
  logic oe_prev = 1'b0;
  logic [7:0] model [8];
  bit done = 1'b0;

  function automatic logic [7:0] exp_reset(input int i);
    return 8'hA0 | 8'(i);
  endfunction

  function automatic bit exp_reg_ok(input logic [7:0] a);
    return a <= 8'd7;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        stb_cnt++;
        last_a = wr_addr;
        last_d = wr_data;
      end
      if (sda_oe != oe_prev && scl_in) hi_changes++;
    end
    oe_prev = sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gs, input int gc, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (i == gc) begin
        wait_clk(3); glitch_scl = 1'b1; wait_clk(2); glitch_scl = 1'b0; wait_clk(Q - 5);
      end else wait_clk(Q);
      scl_m = 1'b1;
      if (i == gs) begin
        wait_clk(4); glitch_sda = 1'b1; wait_clk(2); glitch_sda = 1'b0; wait_clk(2 * Q - 6);
      end else wait_clk(2 * Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    ack = ~sda_line;
    stb_at_ack = stb_cnt;
    wait_clk(Q);
    scl_m = 1'b0;
  endtask

  task automatic read_byte(input bit ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      b[i] = sda_line;
      wait_clk(Q);
      scl_m = 1'b0;
    end
    sda_m = ~ack; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2 * Q);
    scl_m = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] ra, input logic [7:0] d, input int gs, input int gc,
                          input string req);
    bit ack;
    int s0;
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h54, -1, -1, ack);
    check({req, " R1 write header ack"}, 32'(ack), 32'd1);
    send_byte(ra, -1, -1, ack);
    check({req, " R3 index ack"}, 32'(ack), 32'(exp_reg_ok(ra)));
    send_byte(d, gs, gc, ack);
    if (exp_reg_ok(ra)) begin
      check({req, " R4 data ack"}, 32'(ack), 32'd1);
      check({req, " R4 no strobe before ack sampled"}, 32'(stb_at_ack), 32'(s0));
    end else begin
      check({req, " R3 data after bad index refused"}, 32'(ack), 32'd0);
    end
    bus_stop();
    wait_clk(4);
    if (exp_reg_ok(ra)) begin
      check({req, " R4 one strobe"}, 32'(stb_cnt), 32'(s0 + 1));
      check({req, " R4 strobe index/data"}, {16'd0, last_a, last_d}, {16'd0, ra, d});
      model[ra[2:0]] = d;
    end else begin
      check({req, " R3 no strobe"}, 32'(stb_cnt), 32'(s0));
    end
  endtask

  task automatic do_read(input logic [7:0] ra, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'h54, -1, -1, ack);
    check({req, " R1 header ack"}, 32'(ack), 32'd1);
    send_byte(ra, -1, -1, ack);
    check({req, " R3 index ack"}, 32'(ack), 32'(exp_reg_ok(ra)));
    if (exp_reg_ok(ra)) begin
      bus_rstart();
      send_byte(8'h55, -1, -1, ack);
      check({req, " R1 read header ack"}, 32'(ack), 32'd1);
      read_byte(1'b0, b);
      check({req, " R5 read data"}, 32'(b), 32'(model[ra[2:0]]));
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int s0;
    void'($urandom(32'h1C2A_5EED));
    for (int i = 0; i < 8; i++) model[i] = exp_reset(i);
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    check("R7 sda released after reset", 32'(sda_oe), 32'd0);
    check("R7 strobe low after reset", 32'(wr_stb), 32'd0);
    do_read(8'd3, "R7 reset value reg3");
    do_read(8'd7, "R7 reset value reg7");

    // R1: foreign address refused, later bytes refused until next START
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h56, -1, -1, ack);
    check("R1 foreign address refused", 32'(ack), 32'd0);
    send_byte(8'h54, -1, -1, ack);
    check("R1 stays silent until START", 32'(ack), 32'd0);
    bus_stop();
    check("R1 no strobe", 32'(stb_cnt), 32'(s0));

    // R2: repeated START after a completed write re-arms address matching
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h54, -1, -1, ack);
    send_byte(8'd2, -1, -1, ack);
    send_byte(8'h3C, -1, -1, ack);
    check("R2 data ack before restart", 32'(ack), 32'd1);
    bus_rstart();
    send_byte(8'h54, -1, -1, ack);
    check("R2 header ack after repeated START", 32'(ack), 32'd1);
    send_byte(8'd2, -1, -1, ack);
    check("R2 index ack after repeated START", 32'(ack), 32'd1);
    bus_rstart();
    send_byte(8'h55, -1, -1, ack);
    check("R2 read header ack", 32'(ack), 32'd1);
    read_byte(1'b0, b);
    check("R2 read back after restart", 32'(b), 32'h3C);
    bus_stop();
    check("R2 single strobe", 32'(stb_cnt), 32'(s0 + 1));
    model[2] = 8'h3C;

    // R9: extra byte after the data byte refused
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h54, -1, -1, ack);
    send_byte(8'd1, -1, -1, ack);
    send_byte(8'h11, -1, -1, ack);
    send_byte(8'h22, -1, -1, ack);
    check("R9 extra byte refused", 32'(ack), 32'd0);
    bus_stop();
    wait_clk(4);
    check("R9 strobe count", 32'(stb_cnt), 32'(s0 + 1));
    check("R9 strobe data kept", 32'(last_d), 32'h11);
    model[1] = 8'h11;

    // R3: index just outside the bank
    do_write(8'd8, 8'h5A, -1, -1, "R3 edge index 8");

    // R8: glitches on SDA (SCL high) and on SCL (SCL low) in the data byte
    do_write(8'd5, 8'hFF, 3, 5, "R8 glitched byte");

    // R6: controller ACK repeats the register, NAK releases the line
    bus_start();
    send_byte(8'h54, -1, -1, ack);
    send_byte(8'd4, -1, -1, ack);
    bus_rstart();
    send_byte(8'h55, -1, -1, ack);
    read_byte(1'b1, b);
    check("R6 first read byte", 32'(b), 32'(model[4]));
    read_byte(1'b0, b);
    check("R6 repeated read byte", 32'(b), 32'(model[4]));
    wait_clk(Q);
    check("R6 released after NAK", 32'(sda_oe), 32'd0);
    read_byte(1'b0, b);
    check("R6 bits after NAK read high", 32'(b), 32'hFF);
    bus_stop();

    // Random mix of writes and reads, valid and invalid indices
    for (int n = 0; n < 30; n++) begin
      logic [7:0] ra, d;
      ra = 8'($urandom_range(0, 11));
      d  = 8'($urandom);
      if ($urandom_range(0, 1) == 1) do_write(ra, d, -1, -1, "R4 random write");
      else do_read(ra, "R5 random read");
    end

    check("R5 no drive change while SCL high", 32'(hi_changes), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule